// File: doc/BRIEF.md
# Embedded Core Test Wrapper

This block sits between one embedded core and the surrounding chip logic. It decides whether the core's terminals see ordinary functional traffic or test traffic. Test access comes in through a serial port with a data input, a data output and four strobes: shift, capture, update and an instruction-select line. The select line puts either the instruction register or one data register between serial in and serial out.

The instruction is shifted in serially and takes effect only when it is updated. It picks one of four operating modes:

- **Normal:** the wrapper is transparent.
- **Core test:** the boundary cells drive the core inputs and capture the core outputs.
- **Interconnect test:** the boundary cells drive the chip-side wiring and capture what arrives from it.
- **Bypass:** a single flip-flop carries serial data past the core in one clock.

Each core terminal has one boundary cell. Each cell has a shift stage and a separate update stage, so the values driven onto the terminals do not move while new data is being shifted.

Top module: `core_test_wrapper`

## Requirements
- R1: After the active-low reset `rst_n` is released, the active instruction is normal (000). All shift and update stages are zero, `core_in` equals `sys_in`, `sys_out` equals `core_out`, and `ser_out` is 0.
- R2: In normal mode, `core_in` follows `sys_in` and `sys_out` follows `core_out`, whatever the boundary update stages hold.
- R3: The instruction register has a shift stage and an active stage.
  - While `sel_instr`=1 and `shift_en`=1, the shift stage moves one place per clock. `ser_in` enters at the top bit, and `ser_out` shows bit 0, so codes go in LSB first.
  - The active instruction changes only on an update with `sel_instr`=1.
- R4: The active code decodes as follows: 000 is normal, 001 is core test, 010 is interconnect test, and every other code (011 to 111) is bypass.
- R5: In normal and bypass modes with `sel_instr`=0, the data path is a one-bit bypass flop loaded from `ser_in` on each shift. `ser_out` therefore equals `ser_in` delayed by one clock.
- R6: In core test mode, each input cell's update stage drives `core_in[i]` and each output cell's update stage drives `sys_out[j]`.
  - A capture loads each output cell's shift stage from `core_out[j]`.
  - A capture loads each input cell's shift stage from its own update value.
- R7: In interconnect test mode, the terminals are driven as in R6.
  - A capture loads each input cell's shift stage from `sys_in[i]`.
  - A capture loads each output cell's shift stage from its own update value.
- R8: The boundary chain is N_IN+N_OUT long.
  - Cell k (k < N_IN) belongs to input terminal k. Cell N_IN+j belongs to output terminal j.
  - `ser_out` shows cell 0, and `ser_in` enters at the last cell. After N_IN+N_OUT shifts, the first bit shifted in sits in cell 0.
- R9: The values driven in the test modes change only on an update with `sel_instr`=0. Shifting the boundary chain leaves `core_in` and `sys_out` unchanged.
- R10: A capture with `sel_instr`=1 loads the active instruction into the instruction shift stage, so it can be read back on `ser_out`.
- R11: When strobes coincide, capture wins over shift and shift wins over update. Strobes given with `sel_instr`=1 do not change any data register, and strobes given with `sel_instr`=0 do not change the instruction register.
- R12: A capture while the bypass flop is selected clears it to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test and wrapper clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_in | input | 1 | Serial test data input |
| ser_out | output | 1 | Serial test data output of the selected register |
| shift_en | input | 1 | Shift strobe for the selected register |
| capture_en | input | 1 | Capture strobe for the selected register |
| update_en | input | 1 | Update strobe for the selected register |
| sel_instr | input | 1 | 1 selects the instruction register, 0 the data register chosen by the mode |
| sys_in | input | N_IN | Chip-side signals headed for the core inputs |
| core_in | output | N_IN | Signals delivered to the core inputs |
| core_out | input | N_OUT | Core output terminals |
| sys_out | output | N_OUT | Signals delivered to chip-side logic |

## Verification
The hardest state to reach from the ports is one where the shift stage, the update stage and the captured value of a cell all differ, and the active instruction differs from the code waiting in the instruction shift stage. Only in that state can a check tell a wrong capture source, a missing update, or a shift that leaks onto the terminals apart from correct behaviour. The bench loads a known update pattern first. It then shifts in an unrelated pattern without updating and presents a third value on the terminals before capturing. It reads everything back serially and checks it against bench-side copies. Every instruction code is swept and read back, and strobe collisions are issued once the cells are in such a mixed state.

// File: rtl/cw_pkg.sv
package cw_pkg;

    localparam int IR_W = 3;

    typedef enum logic [1:0] {
        MODE_NORMAL       = 2'd0,
        MODE_CORE         = 2'd1,
        MODE_INTERCONNECT = 2'd2,
        MODE_BYPASS       = 2'd3
    } cw_mode_e;

    localparam logic [IR_W-1:0] OP_NORMAL       = 3'b000;
    localparam logic [IR_W-1:0] OP_CORE         = 3'b001;
    localparam logic [IR_W-1:0] OP_INTERCONNECT = 3'b010;
    localparam logic [IR_W-1:0] OP_BYPASS       = 3'b111;

    function automatic cw_mode_e decode_op(input logic [IR_W-1:0] op);
        cw_mode_e m;
        case (op)
            OP_NORMAL:       m = MODE_NORMAL;
            OP_CORE:         m = MODE_CORE;
            OP_INTERCONNECT: m = MODE_INTERCONNECT;
            default:         m = MODE_BYPASS;
        endcase
        return m;
    endfunction

    function automatic logic is_test_mode(input cw_mode_e m);
        return (m == MODE_CORE) || (m == MODE_INTERCONNECT);
    endfunction

endpackage

// File: rtl/cw_instr_reg.sv
module cw_instr_reg
    import cw_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ser_in,
    input  logic            sel,
    input  logic            shift_en,
    input  logic            capture_en,
    input  logic            update_en,
    output logic            ir_so,
    output logic [IR_W-1:0] ir_shift,
    output cw_mode_e        mode
);

    typedef struct packed {
        logic [IR_W-1:0] sh;
        logic [IR_W-1:0] act;
    } ir_state_t;

    ir_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (sel) begin
            if (capture_en) begin
                state_d.sh = state_q.act;
            end else if (shift_en) begin
                state_d.sh = {ser_in, state_q.sh[IR_W-1:1]};
            end else if (update_en) begin
                state_d.act = state_q.sh;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '{sh: '0, act: OP_NORMAL};
        end else begin
            state_q <= state_d;
        end
    end

    assign ir_so    = state_q.sh[0];
    assign ir_shift = state_q.sh;
    assign mode     = decode_op(state_q.act);

endmodule

// File: rtl/cw_bypass.sv
module cw_bypass (
    input  logic clk,
    input  logic rst_n,
    input  logic ser_in,
    input  logic sel,
    input  logic shift_en,
    input  logic capture_en,
    output logic byp_so
);

    typedef struct packed {
        logic bit_v;
    } byp_state_t;

    byp_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (sel) begin
            if (capture_en) begin
                state_d.bit_v = 1'b0;
            end else if (shift_en) begin
                state_d.bit_v = ser_in;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign byp_so = state_q.bit_v;

endmodule

// File: rtl/cw_boundary.sv
module cw_boundary
    import cw_pkg::*;
#(
    parameter int N_IN  = 4,
    parameter int N_OUT = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ser_in,
    input  logic             sel,
    input  logic             shift_en,
    input  logic             capture_en,
    input  logic             update_en,
    input  cw_mode_e         mode,
    input  logic [N_IN-1:0]  sys_in,
    input  logic [N_OUT-1:0] core_out,
    output logic             br_so,
    output logic [N_IN-1:0]  in_upd,
    output logic [N_OUT-1:0] out_upd
);

    localparam int BR_LEN = N_IN + N_OUT;

    typedef struct packed {
        logic [BR_LEN-1:0] sh;
        logic [BR_LEN-1:0] upd;
    } br_state_t;

    br_state_t         state_d, state_q;
    logic [BR_LEN-1:0] cap_val;

    for (genvar i = 0; i < N_IN; i++) begin : g_in_cell
        assign cap_val[i] = (mode == MODE_INTERCONNECT) ? sys_in[i] : state_q.upd[i];
    end

    for (genvar j = 0; j < N_OUT; j++) begin : g_out_cell
        assign cap_val[N_IN+j] = (mode == MODE_CORE) ? core_out[j] : state_q.upd[N_IN+j];
    end

    always_comb begin
        state_d = state_q;
        if (sel) begin
            if (capture_en) begin
                state_d.sh = cap_val;
            end else if (shift_en) begin
                state_d.sh = {ser_in, state_q.sh[BR_LEN-1:1]};
            end else if (update_en) begin
                state_d.upd = state_q.sh;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign br_so   = state_q.sh[0];
    assign in_upd  = state_q.upd[N_IN-1:0];
    assign out_upd = state_q.upd[BR_LEN-1:N_IN];

endmodule

// File: rtl/core_test_wrapper.sv
module core_test_wrapper
    import cw_pkg::*;
#(
    parameter int N_IN  = 4,
    parameter int N_OUT = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ser_in,
    output logic             ser_out,
    input  logic             shift_en,
    input  logic             capture_en,
    input  logic             update_en,
    input  logic             sel_instr,
    input  logic [N_IN-1:0]  sys_in,
    output logic [N_IN-1:0]  core_in,
    input  logic [N_OUT-1:0] core_out,
    output logic [N_OUT-1:0] sys_out
);

    cw_mode_e         cur_mode;
    logic [IR_W-1:0]  ir_shadow;
    logic             ir_so, br_so, byp_so;
    logic             test_drive;
    logic             br_sel, byp_sel;
    logic [N_IN-1:0]  in_upd;
    logic [N_OUT-1:0] out_upd;

    assign test_drive = is_test_mode(cur_mode);
    assign br_sel     = !sel_instr && test_drive;
    assign byp_sel    = !sel_instr && !test_drive;

    cw_instr_reg u_ir (
        .clk        (clk),
        .rst_n      (rst_n),
        .ser_in     (ser_in),
        .sel        (sel_instr),
        .shift_en   (shift_en),
        .capture_en (capture_en),
        .update_en  (update_en),
        .ir_so      (ir_so),
        .ir_shift   (ir_shadow),
        .mode       (cur_mode)
    );

    cw_bypass u_byp (
        .clk        (clk),
        .rst_n      (rst_n),
        .ser_in     (ser_in),
        .sel        (byp_sel),
        .shift_en   (shift_en),
        .capture_en (capture_en),
        .byp_so     (byp_so)
    );

    cw_boundary #(
        .N_IN  (N_IN),
        .N_OUT (N_OUT)
    ) u_br (
        .clk        (clk),
        .rst_n      (rst_n),
        .ser_in     (ser_in),
        .sel        (br_sel),
        .shift_en   (shift_en),
        .capture_en (capture_en),
        .update_en  (update_en),
        .mode       (cur_mode),
        .sys_in     (sys_in),
        .core_out   (core_out),
        .br_so      (br_so),
        .in_upd     (in_upd),
        .out_upd    (out_upd)
    );

    for (genvar i = 0; i < N_IN; i++) begin : g_core_in
        assign core_in[i] = test_drive ? in_upd[i] : sys_in[i];
    end

    for (genvar j = 0; j < N_OUT; j++) begin : g_sys_out
        assign sys_out[j] = test_drive ? out_upd[j] : core_out[j];
    end

    always_comb begin
        if (sel_instr) begin
            ser_out = ir_so;
        end else if (test_drive) begin
            ser_out = br_so;
        end else begin
            ser_out = byp_so;
        end
    end

endmodule

// File: rtl/cw_checker.sv
module cw_checker
    import cw_pkg::*;
#(
    parameter int N_IN  = 4,
    parameter int N_OUT = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ser_in,
    input logic             ser_out,
    input logic             shift_en,
    input logic             capture_en,
    input logic             update_en,
    input logic             sel_instr,
    input logic [N_IN-1:0]  sys_in,
    input logic [N_IN-1:0]  core_in,
    input logic [N_OUT-1:0] core_out,
    input logic [N_OUT-1:0] sys_out,
    input cw_mode_e         mode,
    input logic [IR_W-1:0]  ir_shadow
);

    // R2: normal mode passes both directions straight through
    p_normal_transparent_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_NORMAL) |-> (core_in == sys_in && sys_out == core_out));

    // R3: the active mode only moves on an instruction update
    p_mode_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel_instr && update_en) |=> $stable(mode));

    // R4: an instruction update installs the decoded shift-stage code
    p_ir_update_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_instr && update_en && !shift_en && !capture_en)
        |=> (mode == decode_op($past(ir_shadow))));

    // R5: the bypass path delays serial data by exactly one clock
    p_bypass_lag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == MODE_NORMAL || mode == MODE_BYPASS) && !sel_instr && shift_en && !capture_en)
        |=> (sel_instr || ser_out == $past(ser_in)));

    // R9: driven test values stay put without an update strobe
    p_drive_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (is_test_mode(mode) && !update_en) |=> ($stable(core_in) && $stable(sys_out)));

endmodule

bind core_test_wrapper cw_checker #(
    .N_IN  (N_IN),
    .N_OUT (N_OUT)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ser_in     (ser_in),
    .ser_out    (ser_out),
    .shift_en   (shift_en),
    .capture_en (capture_en),
    .update_en  (update_en),
    .sel_instr  (sel_instr),
    .sys_in     (sys_in),
    .core_in    (core_in),
    .core_out   (core_out),
    .sys_out    (sys_out),
    .mode       (cur_mode),
    .ir_shadow  (ir_shadow)
);

// File: tb/core_test_wrapper_tb.sv
module core_test_wrapper_tb;

    localparam int N_IN  = 4;
    localparam int N_OUT = 3;
    localparam int BR    = N_IN + N_OUT;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ser_in = 1'b0;
    logic             ser_out;
    logic             shift_en = 1'b0;
    logic             capture_en = 1'b0;
    logic             update_en = 1'b0;
    logic             sel_instr = 1'b0;
    logic [N_IN-1:0]  sys_in = '0;
    logic [N_IN-1:0]  core_in;
    logic [N_OUT-1:0] core_out = '0;
    logic [N_OUT-1:0] sys_out;

    int checks = 0;
    int failures = 0;
    logic [BR-1:0] exp_upd = '0;

    always #10 clk = ~clk;

    core_test_wrapper #(.N_IN(N_IN), .N_OUT(N_OUT)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .ser_in     (ser_in),
        .ser_out    (ser_out),
        .shift_en   (shift_en),
        .capture_en (capture_en),
        .update_en  (update_en),
        .sel_instr  (sel_instr),
        .sys_in     (sys_in),
        .core_in    (core_in),
        .core_out   (core_out),
        .sys_out    (sys_out)
    );

    task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic op(input logic sh, input logic cap, input logic upd, input logic sir, input logic sin);
        shift_en = sh; capture_en = cap; update_en = upd; sel_instr = sir; ser_in = sin;
        @(posedge clk);
        @(negedge clk);
        shift_en = 1'b0; capture_en = 1'b0; update_en = 1'b0;
    endtask

    task automatic load_ir(input logic [2:0] code);
        for (int i = 0; i < 3; i++) op(1'b1, 1'b0, 1'b0, 1'b1, code[i]);
        op(1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
        sel_instr = 1'b0;
    endtask

    task automatic read_ir(output logic [2:0] code);
        op(1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
        for (int i = 0; i < 3; i++) begin
            code[i] = ser_out;
            op(1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
        end
        sel_instr = 1'b0;
    endtask

    task automatic br_xfer(input logic [BR-1:0] din, output logic [BR-1:0] dout);
        for (int i = 0; i < BR; i++) begin
            dout[i] = ser_out;
            op(1'b1, 1'b0, 1'b0, 1'b0, din[i]);
        end
    endtask

    task automatic check_transparent(input string req);
        check(core_in == sys_in, req, 32'(core_in), 32'(sys_in));
        check(sys_out == core_out, req, 32'(sys_out), 32'(core_out));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        logic [2:0]    rd;
        logic [BR-1:0] dout;
        logic [BR-1:0] din;
        repeat (3) @(negedge clk);
        sys_in = 4'h9; core_out = 3'h5;
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check_transparent("R1");
        check(ser_out == 1'b0, "R1 ser_out", 32'(ser_out), 0);

        // R3: shifting an instruction without update keeps the mode; old bits come out LSB first
        sys_in = 4'h5;
        for (int i = 0; i < 3; i++) begin
            check(ser_out == 1'b0, "R3 old ir bit", 32'(ser_out), 0);
            op(1'b1, 1'b0, 1'b0, 1'b1, (i == 0));
        end
        check(ser_out == 1'b1, "R3 shifted lsb", 32'(ser_out), 1);
        check_transparent("R3 no update yet");
        op(1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
        sel_instr = 1'b0;
        check(core_in == 4'h0, "R3 core mode after update", 32'(core_in), 0);

        // R4 / R10 / R5: sweep every instruction code
        for (int c = 0; c < 8; c++) begin
            load_ir(3'(c));
            read_ir(rd);
            check(rd == 3'(c), "R10 readback", 32'(rd), 32'(c));
            sys_in = 4'(c) ^ 4'hA;
            core_out = 3'(c) ^ 3'h6;
            @(negedge clk);
            if (c == 1 || c == 2) begin
                check(core_in == exp_upd[N_IN-1:0], "R4 test drive in", 32'(core_in), 32'(exp_upd[N_IN-1:0]));
                check(sys_out == exp_upd[BR-1:N_IN], "R4 test drive out", 32'(sys_out), 32'(exp_upd[BR-1:N_IN]));
            end else begin
                check_transparent("R4 transparent");
                op(1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
                check(ser_out == 1'b1, "R5 lag one", 32'(ser_out), 1);
                op(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
                check(ser_out == 1'b0, "R5 lag zero", 32'(ser_out), 0);
            end
        end

        // R6 / R8 / R9: core test drive sweep
        load_ir(3'b001);
        for (int p = 0; p < 16; p++) begin
            din = {3'(p) ^ 3'b101, 4'(p)};
            br_xfer(din, dout);
            check(core_in == exp_upd[N_IN-1:0], "R9 shift leaves drive", 32'(core_in), 32'(exp_upd[N_IN-1:0]));
            op(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
            exp_upd = din;
            check(core_in == 4'(p), "R6 core_in drive", 32'(core_in), 32'(p));
            check(sys_out == (3'(p) ^ 3'b101), "R6 sys_out drive", 32'(sys_out), 32'(3'(p) ^ 3'b101));
        end
        // R6 / R8: capture observes core outputs
        for (int q = 0; q < 8; q++) begin
            core_out = 3'(q);
            sys_in = 4'(q) ^ 4'hF;
            op(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
            br_xfer('0, dout);
            check(dout[BR-1:N_IN] == 3'(q), "R6 capture core_out", 32'(dout[BR-1:N_IN]), 32'(q));
            check(dout[N_IN-1:0] == exp_upd[N_IN-1:0], "R8 input cells order", 32'(dout[N_IN-1:0]), 32'(exp_upd[N_IN-1:0]));
        end

        // R7: interconnect test
        load_ir(3'b010);
        br_xfer(7'b1010011, dout);
        op(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        exp_upd = 7'b1010011;
        check(sys_out == 3'b101, "R7 sys_out drive", 32'(sys_out), 32'h5);
        for (int p = 0; p < 16; p++) begin
            sys_in = 4'(p);
            core_out = ~3'(p);
            op(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
            br_xfer('0, dout);
            check(dout[N_IN-1:0] == 4'(p), "R7 capture sys_in", 32'(dout[N_IN-1:0]), 32'(p));
            check(dout[BR-1:N_IN] == exp_upd[BR-1:N_IN], "R7 output cells hold", 32'(dout[BR-1:N_IN]), 32'(exp_upd[BR-1:N_IN]));
        end

        // R11: strobe priority and path separation
        br_xfer(7'h55, dout);
        sys_in = 4'h3;
        op(1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
        br_xfer('0, dout);
        check(dout == {exp_upd[BR-1:N_IN], 4'h3}, "R11 capture beats shift", 32'(dout), 32'({exp_upd[BR-1:N_IN], 4'h3}));
        br_xfer(7'h2A, dout);
        op(1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
        check(core_in == exp_upd[N_IN-1:0], "R11 shift beats update", 32'(core_in), 32'(exp_upd[N_IN-1:0]));
        op(1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
        sel_instr = 1'b0;
        check(core_in == exp_upd[N_IN-1:0], "R11 ir update spares cells", 32'(core_in), 32'(exp_upd[N_IN-1:0]));
        check(sys_out == exp_upd[BR-1:N_IN], "R11 ir update keeps mode", 32'(sys_out), 32'(exp_upd[BR-1:N_IN]));

        // R12: bypass capture clears the flop
        load_ir(3'b111);
        op(1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
        check(ser_out == 1'b1, "R12 bypass loaded", 32'(ser_out), 1);
        op(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        check(ser_out == 1'b0, "R12 bypass capture", 32'(ser_out), 0);

        // R2: normal mode with non-zero update stages
        load_ir(3'b000);
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 8; b++) begin
                sys_in = 4'(a);
                core_out = 3'(b);
                @(negedge clk);
                check_transparent("R2 normal");
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule